// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads a four-level radix page table that sits in memory. A caller hands over the virtual address together with the physical base of the root table. The walker then fetches one 64-bit entry per level through a single read port. Each fetch waits as long as the port needs, both for the request to be taken and for the data to come back.

Every table holds 512 eight-byte entries and starts on a 4 KiB boundary. The address of an entry is therefore the table's page number placed above the 9-bit index and three zero bits, with no adder involved. Each fetched entry supplies the page number of the next table, and the last entry supplies the page number of the data page. An entry whose present bit is clear stops the walk at once. The block then reports a fault together with the level that failed.

The walker handles one translation at a time. When a walk ends, the result appears for exactly one cycle.

Top module: `page_walker`

## Requirements
- R1: After reset `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: A request is taken only on a cycle where `req_ready` is 1. A `req_valid` held high while a walk is running has no effect on that walk's reads or result.
- R3: The first read goes to `{req_root[51:12], va[47:39], 3'b000}`. The low 12 bits of `req_root` are ignored.
- R4: Levels 1, 2 and 3 index with `va[38:30]`, `va[29:21]` and `va[20:12]` in that order. Each uses bits [51:12] of the previous entry as the table page number. Entry bits [63:52] and [11:1] take no part in any address.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` stays stable, for any number of cycles.
- R6: Once a read has been accepted, `mem_req_valid` stays 0 until its `mem_rsp_valid` arrives. A successful walk makes exactly four reads.
- R7: Bit 0 of every entry is the present bit. If it is 0 at level L (0 = root, 3 = last), the walker gives `rsp_valid` with `rsp_fault` = 1 and `rsp_level` = L, and makes no further reads. The walk then makes L+1 reads in total.
- R8: A successful walk gives `rsp_fault` = 0, `rsp_level` = 3 and `rsp_pa = {last_entry[51:12], va[11:0]}`.
- R9: `rsp_valid` lasts exactly one cycle, and `req_ready` is 1 on the following cycle.
- R10: A `mem_rsp_valid` pulse that arrives while no read is awaiting its data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 48 | Virtual address to translate |
| req_root | input | 52 | Root table base (low 12 bits ignored) |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 52 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Fetched table entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_level | output | 2 | Level of the last entry examined |
| rsp_pa | output | 52 | Translated physical address (0 on fault) |

## Verification
Two things can land on the same cycle here. One is a caller's new request arriving while the previous walk's result is being signalled. The other is a stray memory data strobe arriving while a read request is still waiting to be accepted. The bench keeps `req_valid` high with a second address through an entire walk. It then confirms three things: the first walk's reads and result belong only to the first address, `req_ready` is low on the result cycle, and the second walk begins the cycle after. The bench also injects a response pulse carrying an all-ones entry during a stalled read request. It checks that the walk's addresses and final physical address are unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int VA_W  = 48;
    parameter int PA_W  = 52;
    parameter int ENT_W = 64;
    parameter int PG_W  = 12;
    parameter int IDX_W = 9;
    parameter int LVLS  = 4;

    localparam int LVL_W  = $clog2(LVLS);
    localparam int ENT_B  = $clog2(ENT_W / 8);
    localparam int BASE_W = PA_W - PG_W;

    typedef enum logic [2:0] {
        W_IDLE,
        W_READ,
        W_WAIT,
        W_DONE,
        W_FAULT
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        logic [LVL_W-1:0]  level;
        logic [PA_W-1:0]   pa;
    } walk_rsp_t;

    // Index field for a level: level 0 uses the highest field.
    function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va,
                                                  input logic [LVL_W-1:0] lvl);
        int sh;
        sh = PG_W + IDX_W * (LVLS - 1 - int'(lvl));
        return va[sh +: IDX_W];
    endfunction
endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import ptw_pkg::*;
(
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [VA_W-1:0]   va,
    input  logic [LVL_W-1:0]  lvl,
    output logic [PA_W-1:0]   ent_addr
);
    logic unused_va_low;
    assign unused_va_low = ^va[PG_W-1:0];

    // Table is size-aligned: the scaled index simply fills the page offset.
    assign ent_addr = {tbl_base, va_index(va, lvl), {ENT_B{1'b0}}};
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   req_root,
    output logic              req_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic [BASE_W-1:0] cur_base,
    output logic [VA_W-1:0]   cur_va,
    output logic [LVL_W-1:0]  cur_lvl,
    output logic              rsp_valid,
    output walk_rsp_t         rsp
);
    walk_st_e          st;
    logic [BASE_W-1:0] base_q;
    logic [VA_W-1:0]   va_q;
    logic [LVL_W-1:0]  lvl_q;
    walk_rsp_t         rsp_q;
    logic              present;
    logic              last_lvl;
    logic [BASE_W-1:0] ent_base;

    logic unused_bits;
    assign unused_bits = ^{mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[PG_W-1:1],
                           req_root[PG_W-1:0]};

    assign present  = mem_rsp_data[0];
    assign ent_base = mem_rsp_data[PA_W-1:PG_W];
    assign last_lvl = (lvl_q == LVL_W'(LVLS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            base_q <= '0;
            va_q   <= '0;
            lvl_q  <= '0;
            rsp_q  <= '0;
        end else begin
            case (st)
                W_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    base_q <= req_root[PA_W-1:PG_W];
                    lvl_q  <= '0;
                    st     <= W_READ;
                end
                W_READ: if (mem_req_ready) st <= W_WAIT;
                W_WAIT: if (mem_rsp_valid) begin
                    if (!present) begin
                        rsp_q <= '{fault: 1'b1, level: lvl_q, pa: '0};
                        st    <= W_FAULT;
                    end else if (last_lvl) begin
                        rsp_q <= '{fault: 1'b0, level: lvl_q,
                                   pa: {ent_base, va_q[PG_W-1:0]}};
                        st    <= W_DONE;
                    end else begin
                        base_q <= ent_base;
                        lvl_q  <= lvl_q + 1'b1;
                        st     <= W_READ;
                    end
                end
                W_DONE, W_FAULT: st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == W_IDLE);
    assign mem_req_valid = (st == W_READ);
    assign rsp_valid     = (st == W_DONE) || (st == W_FAULT);
    assign rsp           = rsp_q;
    assign cur_base      = base_q;
    assign cur_va        = va_q;
    assign cur_lvl       = lvl_q;

    // R6
    one_read_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready && !rsp_valid);

    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp.fault |-> $past(mem_rsp_valid) && !$past(mem_rsp_data[0]));

    // R8
    success_level_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp.fault |-> rsp.level == LVL_W'(LVLS - 1) && $past(mem_rsp_data[0]));
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   req_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [LVL_W-1:0]  rsp_level,
    output logic [PA_W-1:0]   rsp_pa
);
    logic [BASE_W-1:0] cur_base;
    logic [VA_W-1:0]   cur_va;
    logic [LVL_W-1:0]  cur_lvl;
    walk_rsp_t         rsp;

    walk_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_root     (req_root),
        .req_ready    (req_ready),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .cur_base     (cur_base),
        .cur_va       (cur_va),
        .cur_lvl      (cur_lvl),
        .rsp_valid    (rsp_valid),
        .rsp          (rsp)
    );

    walk_addr_gen u_addr (
        .tbl_base(cur_base),
        .va      (cur_va),
        .lvl     (cur_lvl),
        .ent_addr(mem_req_addr)
    );

    assign rsp_fault = rsp.fault;
    assign rsp_level = rsp.level;
    assign rsp_pa    = rsp.pa;

    // R5
    hold_read_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, mem_req_valid, rsp_valid}));
endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [51:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic [51:0] rsp_pa;

    always #10 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_level(rsp_level), .rsp_pa(rsp_pa)
    );

    int nchk = 0;
    int nfail = 0;
    bit reported = 0;
    int lat = 0;
    int stall = 0;
    bit spur = 0;

    logic [63:0] mem [logic [51:0]];
    logic [51:0] rlog [8];
    int          nreads = 0;
    logic [51:0] exp_a [4];
    logic [51:0] exp_b [4];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        end
    endtask

    function automatic logic [51:0] ent_addr(input logic [51:0] base, input logic [47:0] va, input int l);
        logic [8:0] idx;
        idx = va[47 - 9*l -: 9];
        return {base[51:12], idx, 3'b000};
    endfunction

    function automatic logic [63:0] mk_entry(input logic [51:0] nxt, input bit present);
        return {12'hC3B, nxt[51:12], 11'h2D0, present};
    endfunction

    // Memory model: optional accept stall, optional stray strobe, response latency.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [51:0] a;
                a = mem_req_addr;
                for (int i = 0; i < stall; i++) begin
                    mem_rsp_valid = spur && (i == 0);
                    mem_rsp_data  = spur ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
                    @(negedge clk);
                    // R5: request held and stable while not accepted
                    chk(mem_req_valid && mem_req_addr == a, "R5 held addr", {12'h0, mem_req_addr}, {12'h0, a});
                end
                mem_rsp_valid = 1'b0;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (nreads < 8) rlog[nreads] = a;
                nreads++;
                for (int i = 0; i < lat; i++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    // Build a chain of tables; exp_a receives the expected read addresses.
    task automatic build(input logic [47:0] va, input logic [51:0] root,
                         input logic [51:0] t1, input logic [51:0] t2,
                         input logic [51:0] t3, input logic [51:0] leaf, input int flt);
        logic [51:0] b [5];
        b[0] = root; b[1] = t1; b[2] = t2; b[3] = t3; b[4] = leaf;
        for (int l = 0; l < 4; l++) begin
            exp_a[l] = ent_addr(b[l], va, l);
            mem[exp_a[l]] = mk_entry(b[l+1], l != flt);
        end
    endtask

    task automatic issue(input logic [47:0] va, input logic [51:0] root);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_root = root;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        while (!rsp_valid) @(negedge clk);
    endtask

    task automatic walk(input string tag, input logic [47:0] va, input logic [51:0] root,
                        input bit efault, input int elvl, input logic [51:0] epa, input int ereads);
        nreads = 0;
        issue(va, root);
        wait_rsp();
        chk(rsp_fault == efault, {tag, " R7/R8 fault"}, rsp_fault, efault);
        chk(rsp_level == 2'(elvl), {tag, " R7/R8 level"}, rsp_level, elvl);
        chk(rsp_pa == epa, {tag, " R8 pa"}, rsp_pa, epa);
        @(negedge clk);
        // R9: one-cycle strobe, ready again
        chk(!rsp_valid && req_ready, {tag, " R9 pulse"}, {rsp_valid, req_ready}, 2'b01);
        repeat (3) @(negedge clk);
        // R6 / R7: read count, nothing further after fault
        chk(nreads == ereads && !mem_req_valid, {tag, " R6/R7 reads"}, nreads, ereads);
        for (int l = 0; l < ereads && l < 4; l++)
            chk(rlog[l] == exp_a[l], {tag, " R3/R4 addr"}, rlog[l], exp_a[l]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R1 idle outputs", {mem_req_valid, rsp_valid}, 0);
    endtask

    task automatic t_basic();
        logic [47:0] va = 48'h8A5C_3F12_7ABC;
        mem.delete(); lat = 0; stall = 0; spur = 0;
        // R3: root carries junk in its low 12 bits
        build(va, 52'h0_0012_3456_7FFF, 52'h0_00AB_CDEF_1000, 52'h0_0000_0042_0000,
              52'h0_7777_0000_3000, 52'h0_4321_8765_9000, -1);
        exp_a[0] = ent_addr(52'h0_0012_3456_7000, va, 0);
        mem[exp_a[0]] = mk_entry(52'h0_00AB_CDEF_1000, 1);
        walk("basic", va, 52'h0_0012_3456_7FFF, 0, 3, {40'h4_3218_7659, va[11:0]}, 4);
    endtask

    task automatic t_slow();
        logic [47:0] va = 48'h0001_FFFF_F123;
        mem.delete(); lat = 3; stall = 2; spur = 0;
        build(va, 52'h0_0000_0001_0000, 52'h0_0000_0002_0000, 52'h0_0000_0003_0000,
              52'h0_0000_0004_0000, 52'h0_000F_EDCB_A000, -1);
        walk("slow R5", va, 52'h0_0000_0001_0000, 0, 3, {40'h0_00FE_DCBA, va[11:0]}, 4);
    endtask

    task automatic t_fault(input int fl);
        logic [47:0] va = 48'hFFFF_0000_AAAA;
        mem.delete(); lat = 1; stall = 0; spur = 0;
        build(va, 52'h0_1000_0000_0000, 52'h0_2000_0000_0000, 52'h0_3000_0000_0000,
              52'h0_4000_0000_0000, 52'h0_5000_0000_0000, fl);
        walk("fault R7", va, 52'h0_1000_0000_0000, 1, fl, 52'h0, fl + 1);
    endtask

    task automatic t_stray();
        logic [47:0] va = 48'h1234_5678_9ABC;
        mem.delete(); lat = 2; stall = 3; spur = 1;
        build(va, 52'h0_0000_0AAA_A000, 52'h0_0000_0BBB_B000, 52'h0_0000_0CCC_C000,
              52'h0_0000_0DDD_D000, 52'h0_0000_0EEE_E000, -1);
        // R10: stray strobes during stalled requests leave the walk unchanged
        walk("stray R10", va, 52'h0_0000_0AAA_A000, 0, 3, {40'h0_0000_EEEE, va[11:0]}, 4);
        spur = 0;
    endtask

    task automatic t_overlap();
        logic [47:0] va_a = 48'h0F0F_0F0F_0F0F;
        logic [47:0] va_b = 48'hF0F0_F0F0_F0F0;
        mem.delete(); lat = 1; stall = 1; spur = 0;
        build(va_b, 52'h0_0009_0000_0000, 52'h0_0009_1000_0000, 52'h0_0009_2000_0000,
              52'h0_0009_3000_0000, 52'h0_0009_4444_4000, -1);
        for (int l = 0; l < 4; l++) exp_b[l] = exp_a[l];
        build(va_a, 52'h0_0001_0000_0000, 52'h0_0001_1000_0000, 52'h0_0001_2000_0000,
              52'h0_0001_3000_0000, 52'h0_0001_5555_5000, -1);
        nreads = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va_a; req_root = 52'h0_0001_0000_0000;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_va = va_b; req_root = 52'h0_0009_0000_0000;
        wait_rsp();
        // R2: busy walker ignores the pending request
        chk(!req_ready, "overlap R2 not ready on result", req_ready, 0);
        chk(rsp_pa == {40'h1_5555_5, va_a[11:0]}, "overlap R2 first pa", rsp_pa, {40'h1_5555_5, va_a[11:0]});
        chk(nreads == 4, "overlap R2 first reads", nreads, 4);
        for (int l = 0; l < 4; l++)
            chk(rlog[l] == exp_a[l], "overlap R2 first addr", rlog[l], exp_a[l]);
        @(negedge clk);
        chk(req_ready, "overlap R9 ready after result", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp();
        chk(!rsp_fault && rsp_pa == {40'h9_4444_4, va_b[11:0]}, "overlap R8 second pa", rsp_pa, {40'h9_4444_4, va_b[11:0]});
        @(negedge clk);
        chk(nreads == 8, "overlap R6 second reads", nreads, 8);
        for (int l = 0; l < 4; l++)
            chk(rlog[4+l] == exp_b[l], "overlap R4 second addr", rlog[4+l], exp_b[l]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_slow();
        t_fault(0);
        t_fault(2);
        t_fault(3);
        t_stray();
        t_overlap();
        repeat (4) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired: run hung");
        report();
        $finish;
    end
endmodule